// File: doc/BRIEF.md
# Flash command sequencer

This block is the control core of a byte-wide parallel NOR flash model. It watches bus write cycles and looks for command sequences that start with a pair of unlock writes at fixed addresses. The sequences it accepts are program, sector erase, chip erase, autoselect and reset. A program or erase starts a busy phase whose length is a parameter counted in clock cycles, so simulations can use short values. The block also holds a small register-based byte array that is split into equal sectors.

While an operation runs, a read returns a status byte instead of array data. Bit 7 is the complement of the final value's top bit, and bit 6 flips on every read. When the operation ends, the array is updated and reads return stored data again. Writes that arrive while busy are dropped. A sequence with a wrong step returns the machine to read mode. Autoselect mode returns identification bytes in place of array data.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, ry_by is 1, every array byte reads FFh, and the machine is in read mode.
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, then any address/data start a program. Command addresses are compared on the full 16-bit address. When the program finishes, the byte at addr[7:0] holds its old value AND the data, so a program can only clear bits.
- R3: ry_by goes low at the clock edge that takes the last write of a program or erase. It stays low for exactly PROG_CYC cycles (program), SERASE_CYC cycles (sector erase) or CERASE_CYC cycles (chip erase), and it never drops without such a write.
- R4: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then any address with 30h erase one sector: all bytes whose addr[7:5] matches (32-byte sectors by default) become FFh, and other bytes keep their values.
- R5: The same five-write prefix followed by 5555h/10h sets every byte of the array to FFh.
- R6: A read returns its byte on rdata one cycle after rd_en. While busy, that byte has bit 7 equal to the complement of bit 7 of the programmed data (0 during an erase). Bit 6 is 0 on the first busy read after launch and inverts on each later busy read. Bits 5..0 are 0.
- R7: Writes made while busy are ignored. This covers a full program sequence issued during an erase: it changes neither the array nor the sequence state.
- R8: A write that does not match the expected step returns the machine to read mode, and that write does not alter the array. F0h at any step returns to read mode, so a following data write does not program.
- R9: The writes 5555h/AAh, 2AAAh/55h, 5555h/90h enter autoselect. In this mode a read with addr[1:0]=0 returns 40h, with addr[1:0]=1 returns 13h (TOP_BOOT=1) or B3h (TOP_BOOT=0), and with other offsets returns 00h.
- R10: Any write other than 5555h/AAh leaves autoselect, and reads then return array data. rdata holds its value in every cycle without rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, registered one cycle after rd_en |
| ry_by | output | 1 | High when ready, low while an operation runs |

## Verification
The assertions assume that rd_en and wr_en are never high in the same cycle. They also assume that all three duration parameters are at least 1, because the read path and the timer rely on both. The bench issues every bus cycle from a single task that raises exactly one strobe for one cycle, so the two strobes never overlap. It also gives short nonzero durations, so busy phases, status reads and back-to-back commands all fit inside the run.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3, ST_AUTO
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_SERASE, OP_CERASE
  } op_kind_t;

  localparam logic [7:0] BLANK_BYTE   = 8'hFF;
  localparam logic [7:0] KEY_FIRST    = 8'hAA;
  localparam logic [7:0] KEY_SECOND   = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERSETUP = 8'h80;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] VENDOR_CODE  = 8'h40;
  localparam logic [7:0] PART_TOP     = 8'h13;
  localparam logic [7:0] PART_BOTTOM  = 8'hB3;

  function automatic logic [7:0] ident_byte(input logic [1:0] off, input logic top);
    case (off)
      2'd0:    return VENDOR_CODE;
      2'd1:    return top ? PART_TOP : PART_BOTTOM;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] busy_status(input logic final_msb, input logic tog);
    return {~final_msb, tog, 6'b0};
  endfunction

  function automatic logic [7:0] program_merge(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output seq_state_t        state,
  output logic              launch_prog,
  output logic              launch_serase,
  output logic              launch_cerase
);

  localparam logic [ADDR_W-1:0] A_FIRST  = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] A_SECOND = ADDR_W'(16'h2AAA);

  seq_state_t nxt;
  logic at_first, at_second, key1_hit, key2_hit;

  assign at_first  = (addr == A_FIRST);
  assign at_second = (addr == A_SECOND);
  assign key1_hit  = at_first && (wdata == KEY_FIRST);
  assign key2_hit  = at_second && (wdata == KEY_SECOND);

  always_comb begin
    nxt           = state;
    launch_prog   = 1'b0;
    launch_serase = 1'b0;
    launch_cerase = 1'b0;
    if (wr_en && !busy) begin
      case (state)
        ST_READ, ST_AUTO: nxt = key1_hit ? ST_UNL1 : ST_READ;
        ST_UNL1:          nxt = key2_hit ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (at_first && wdata == CODE_PROG)         nxt = ST_PROG;
          else if (at_first && wdata == CODE_ERSETUP) nxt = ST_ERS1;
          else if (at_first && wdata == CODE_IDENT)   nxt = ST_AUTO;
          else                                        nxt = ST_READ;
        end
        ST_PROG: begin
          launch_prog = 1'b1;
          nxt         = ST_READ;
        end
        ST_ERS1: nxt = key1_hit ? ST_ERS2 : ST_READ;
        ST_ERS2: nxt = key2_hit ? ST_ERS3 : ST_READ;
        ST_ERS3: begin
          if (at_first && wdata == CODE_CHIP) launch_cerase = 1'b1;
          else if (wdata == CODE_SECTOR)      launch_serase = 1'b1;
          nxt = ST_READ;
        end
        default: nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_READ;
    else        state <= nxt;
  end

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (launch) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (done) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array
  import flash_seq_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int SECT_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [7:0]               rd_q,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [7:0]               wr_d,
  input  logic                     do_prog,
  input  logic                     do_sect,
  input  logic                     do_chip
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int SECT_SH = $clog2(SECT_BYTES);

  logic [7:0] mem [DEPTH];

  assign rd_q = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
    end else if (do_chip) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
    end else if (do_sect) begin
      for (int i = 0; i < DEPTH; i++)
        if ((IDX_W'(i) >> SECT_SH) == (wr_idx >> SECT_SH)) mem[i] <= BLANK_BYTE;
    end else if (do_prog) begin
      mem[wr_idx] <= program_merge(mem[wr_idx], wr_d);
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int   ADDR_W     = 16,
  parameter int   DEPTH      = 256,
  parameter int   SECT_BYTES = 32,
  parameter int   PROG_CYC   = 2000,
  parameter int   SERASE_CYC = 1000000,
  parameter int   CERASE_CYC = 4000000,
  parameter logic TOP_BOOT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ry_by
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int MAX_E   = (SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC;
  localparam int MAX_CYC = (PROG_CYC > MAX_E) ? PROG_CYC : MAX_E;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t       dec_state;
  op_kind_t         op_kind;
  logic [IDX_W-1:0] op_idx;
  logic [7:0]       op_data;
  logic [7:0]       arr_q;
  logic [CNT_W-1:0] load_val;
  logic             launch_prog, launch_serase, launch_cerase, launch_any;
  logic             busy, op_done, tog;
  logic             commit_prog, commit_sect, commit_chip;

  flash_seq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
    .addr(addr), .wdata(wdata), .state(dec_state),
    .launch_prog(launch_prog), .launch_serase(launch_serase),
    .launch_cerase(launch_cerase)
  );

  assign launch_any = launch_prog | launch_serase | launch_cerase;
  assign load_val   = launch_prog   ? CNT_W'(PROG_CYC)   :
                      launch_serase ? CNT_W'(SERASE_CYC) : CNT_W'(CERASE_CYC);

  flash_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch_any), .load_val(load_val),
    .busy(busy), .done(op_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_kind <= OP_NONE;
      op_idx  <= '0;
      op_data <= BLANK_BYTE;
    end else if (launch_any) begin
      op_kind <= launch_prog ? OP_PROG : (launch_serase ? OP_SERASE : OP_CERASE);
      op_idx  <= addr[IDX_W-1:0];
      op_data <= launch_prog ? wdata : BLANK_BYTE;
    end
  end

  assign commit_prog = op_done && (op_kind == OP_PROG);
  assign commit_sect = op_done && (op_kind == OP_SERASE);
  assign commit_chip = op_done && (op_kind == OP_CERASE);

  flash_seq_array #(.DEPTH(DEPTH), .SECT_BYTES(SECT_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_idx(addr[IDX_W-1:0]), .rd_q(arr_q),
    .wr_idx(op_idx), .wr_d(op_data), .do_prog(commit_prog),
    .do_sect(commit_sect), .do_chip(commit_chip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tog <= 1'b0;
    else if (launch_any)      tog <= 1'b0;
    else if (rd_en && busy)   tog <= ~tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_en) begin
      if (busy)                       rdata <= busy_status(op_data[7], tog);
      else if (dec_state == ST_AUTO)  rdata <= ident_byte(addr[1:0], TOP_BOOT);
      else                            rdata <= arr_q;
    end
  end

  assign ry_by = ~busy;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       ry_by,
  input logic       busy,
  input logic       op_done,
  input logic       launch_prog,
  input logic       launch_serase,
  input logic       launch_cerase,
  input logic [2:0] dec_state
);

  logic launch_any;
  assign launch_any = launch_prog | launch_serase | launch_cerase;

  assert_single_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_prog, launch_serase, launch_cerase}));

  assert_busy_follows_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_any |=> !ry_by);

  assert_ready_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ry_by) |-> $past(op_done));

  assert_no_spurious_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ry_by && !launch_any) |=> ry_by);

  assert_status_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rdata[5:0] == 6'd0));

  assert_launch_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_any |-> !busy);

  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (dec_state == $past(dec_state)));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .ry_by(ry_by), .busy(busy), .op_done(op_done), .launch_prog(launch_prog),
  .launch_serase(launch_serase), .launch_cerase(launch_cerase),
  .dec_state(dec_state)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int P_CYC = 5;
  localparam int S_CYC = 12;
  localparam int C_CYC = 20;
  localparam int NBYTE = 256;
  localparam int SBYTE = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ry_by;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] model [NBYTE];
  logic [7:0] q;
  int n;

  always #5 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(16), .DEPTH(NBYTE), .SECT_BYTES(SBYTE), .PROG_CYC(P_CYC),
    .SERASE_CYC(S_CYC), .CERASE_CYC(C_CYC), .TOP_BOOT(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by(ry_by)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] r);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    r = rdata;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (!ry_by && cyc < 100000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic seq_program(input logic [15:0] a, input logic [7:0] d);
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55);
    bus_wr(16'h5555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic seq_erase_prefix();
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55); bus_wr(16'h5555, 8'h80);
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55);
  endtask

  function automatic void model_prog(input logic [15:0] a, input logic [7:0] d);
    int k = int'(a) % NBYTE;
    for (int b = 0; b < 8; b++) if (!d[b]) model[k][b] = 1'b0;
  endfunction

  function automatic void model_sector(input logic [15:0] a);
    int s = (int'(a) % NBYTE) / SBYTE;
    for (int i = 0; i < NBYTE; i++) if (i / SBYTE == s) model[i] = 8'hFF;
  endfunction

  function automatic logic [7:0] exp_at(input logic [15:0] a);
    return model[int'(a) % NBYTE];
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] ra;
    logic [7:0]  rd8;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NBYTE; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_int("R1 ready", int'(ry_by), 1);
    bus_rd(16'h0000, q); check8("R1 blank", q, 8'hFF);
    bus_rd(16'h00FF, q); check8("R1 blank", q, 8'hFF);

    // R2 program and AND merge, R3 duration
    seq_program(16'h0010, 8'h5A); model_prog(16'h0010, 8'h5A);
    wait_ready(n); check_int("R3 program busy cycles", n, P_CYC);
    bus_rd(16'h0010, q); check8("R2 program", q, exp_at(16'h0010));
    seq_program(16'h0010, 8'hF0); model_prog(16'h0010, 8'hF0);
    wait_ready(n);
    bus_rd(16'h0010, q); check8("R2 and-merge", q, 8'h50);

    // R6 busy status during program (data 5Ah -> bit7 of status 1)
    seq_program(16'h0040, 8'h5A); model_prog(16'h0040, 8'h5A);
    bus_rd(16'h0040, q); check8("R6 status first", q, 8'h80);
    bus_rd(16'h0040, q); check8("R6 status toggle", q, 8'hC0);
    bus_rd(16'h0040, q); check8("R6 status toggle back", q, 8'h80);
    wait_ready(n);
    bus_rd(16'h0040, q); check8("R6 true data after done", q, 8'h5A);
    bus_rd(16'h0040, q); check8("R6 no toggle when ready", q, 8'h5A);

    // R10 rdata holds without rd_en
    repeat (3) @(negedge clk);
    check8("R10 rdata hold", rdata, 8'h5A);

    // R4 sector erase + R6 erase status + R7 program ignored while erasing
    seq_program(16'h0030, 8'h00); model_prog(16'h0030, 8'h00); wait_ready(n);
    seq_erase_prefix(); bus_wr(16'h0055, 8'h30); model_sector(16'h0055);
    bus_rd(16'h0050, q); check8("R6 erase status", q, 8'h00);
    seq_program(16'h0050, 8'h00);
    wait_ready(n); check_int("R3 sector erase busy cycles", n, S_CYC - 5);
    bus_rd(16'h0050, q); check8("R7 program during erase ignored", q, 8'hFF);
    bus_rd(16'h0040, q); check8("R4 sector erased", q, 8'hFF);
    bus_rd(16'h0010, q); check8("R4 other sector kept", q, 8'h50);
    bus_rd(16'h0030, q); check8("R4 other sector kept", q, 8'h00);
    seq_program(16'h0050, 8'h3C); model_prog(16'h0050, 8'h3C); wait_ready(n);
    bus_rd(16'h0050, q); check8("R7 sequencer idle after busy", q, 8'h3C);

    // R8 aborted sequences
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h1234, 8'h55);
    bus_wr(16'h5555, 8'hA0); bus_wr(16'h0020, 8'h00);
    check_int("R8 wrong address no busy", int'(ry_by), 1);
    bus_rd(16'h0020, q); check8("R8 wrong address", q, 8'hFF);
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55);
    bus_wr(16'h5555, 8'hF0); bus_wr(16'h0021, 8'h00);
    bus_rd(16'h0021, q); check8("R8 reset mid-sequence", q, 8'hFF);
    seq_erase_prefix(); bus_wr(16'h5555, 8'h77);
    check_int("R8 bad erase code no busy", int'(ry_by), 1);
    bus_rd(16'h0010, q); check8("R8 bad erase code", q, 8'h50);

    // R9 autoselect, R10 exit
    bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55); bus_wr(16'h5555, 8'h90);
    bus_rd(16'h0000, q); check8("R9 vendor", q, 8'h40);
    bus_rd(16'h0101, q); check8("R9 part top", q, 8'h13);
    bus_rd(16'h0002, q); check8("R9 other offset", q, 8'h00);
    bus_rd(16'h0013, q); check8("R9 other offset", q, 8'h00);
    bus_wr(16'h0000, 8'hF0);
    bus_rd(16'h0010, q); check8("R10 exit autoselect", q, 8'h50);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int sel = int'($urandom % 10);
      ra = 16'($urandom);
      if (ra == 16'h5555 || ra == 16'h2AAA) ra = 16'h0001;
      if (sel < 4) begin
        rd8 = 8'($urandom);
        seq_program(ra, rd8); model_prog(ra, rd8); wait_ready(n);
        bus_rd(ra, q); check8("R2 random program", q, exp_at(ra));
      end else if (sel < 8) begin
        bus_rd(ra, q); check8("R2 random read", q, exp_at(ra));
      end else if (sel == 8) begin
        seq_erase_prefix(); bus_wr(ra, 8'h30); model_sector(ra);
        wait_ready(n); check_int("R3 random erase cycles", n, S_CYC);
        bus_rd(ra ^ 16'h0007, q); check8("R4 random erase", q, exp_at(ra ^ 16'h0007));
      end else begin
        bus_wr(16'h5555, 8'hAA); bus_wr(16'h2AAA, 8'h55);
        bus_wr(16'h5555, 8'h77); bus_wr(ra, 8'h00);
        bus_rd(ra, q); check8("R8 random abort", q, exp_at(ra));
      end
    end

    // R5 chip erase
    seq_erase_prefix(); bus_wr(16'h5555, 8'h10);
    wait_ready(n); check_int("R3 chip erase cycles", n, C_CYC);
    for (int i = 0; i < NBYTE; i += 17) begin
      bus_rd(16'(i), q); check8("R5 chip erased", q, 8'hFF);
    end

    finished = 1;
    report();
    $finish;
  end

endmodule